// File: doc/BRIEF.md
# Interleaved Four-Phase Bit Synchronizer

This block carries one asynchronous bit into a fast clock domain. It does not use a flip-flop chain that shifts on every edge. It uses four parallel lanes, and each lane is a two-flop pair. A lane is enabled on only one edge in four, and each lane starts one edge after the lane before it. On every edge exactly one lane takes a new sample, so the input is still sampled at full clock rate. Between its capture flop and its output flop, each lane gets about four clock periods for a metastable capture to settle.

A free-running phase counter produces the lane enables. A selector placed after the four lane output flops picks the lane that was refreshed on the latest edge. The multiplexer delay therefore comes out of the downstream timing budget and not out of the settling window. Seen from the ports, the block acts as a four-edge delay of the sampled input, and it keeps single-cycle resolution.

Top module: `interleaved_sync`

## Requirements
- R1: While `rst_n` is low, the phase counter and all eight lane flops are 0, so `sync_out` is 0. After release, `sync_out` stays 0 through the fourth rising edge.
- R2: The 2-bit phase counter is 0 on the first edge after reset release. It advances by one on every edge and wraps from 3 to 0.
- R3: On every edge exactly one lane is enabled: the lane whose index equals the current phase.
- R4: A lane's capture flop loads `async_in` only on its enabled edge. On the other three edges it holds its value.
- R5: On its enabled edge, a lane's output flop takes the capture flop's old value, which is the sample from four edges earlier. It holds on all other edges.
- R6: `sync_out` follows the output flop of the lane enabled on the most recent edge.
- R7: After each rising edge n, `sync_out` equals `async_in` as sampled at edge n-4. Samples from before reset release count as 0.
- R8: A one-cycle pulse on `async_in` appears on `sync_out` as exactly one one-cycle pulse, whichever of the four phases captures it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast destination clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| async_in | input | 1 | Asynchronous single-bit input |
| sync_out | output | 1 | Synchronized bit, four edges behind the sample |

## Verification
The bench builds the block with its default of four lanes and a two-bit phase. With that setting a single-cycle pulse can be placed on each of the four phases in turn, and each placement exercises a different lane's capture-to-output path and selector setting. A long bit table with isolated pulses, runs and alternating patterns reaches every lane enable sequence. A reset taken in mid-run checks that no stale lane content leaks out after release.

// File: rtl/isync_pkg.sv
package isync_pkg;
  localparam int DEFAULT_LANES = 4;

  // Two-flop state held by a single lane.
  typedef struct packed {
    logic held;   // output stage
    logic cap;    // capture stage
  } lane_state_t;
endpackage

// File: rtl/isync_phase_gen.sv
module isync_phase_gen #(
  parameter int LANES = isync_pkg::DEFAULT_LANES,
  localparam int PH_W = $clog2(LANES)
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [PH_W-1:0]  phase,
  output logic [LANES-1:0] lane_en,
  output logic [PH_W-1:0]  sel
);
  logic [PH_W-1:0] phase_q, phase_d;

  always_comb begin
    if (phase_q == PH_W'(LANES - 1)) phase_d = '0;
    else                             phase_d = phase_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  // One-hot enable decode, one bit per lane.
  for (genvar i = 0; i < LANES; i++) begin : g_dec
    assign lane_en[i] = (phase_q == PH_W'(i));
  end

  // Lane refreshed on the most recent edge is the one before the current phase.
  always_comb begin
    if (phase_q == '0) sel = PH_W'(LANES - 1);
    else               sel = phase_q - 1'b1;
  end

  assign phase = phase_q;
endmodule

// File: rtl/isync_lane.sv
module isync_lane (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic din,
  output logic cap_q,
  output logic held_q
);
  import isync_pkg::*;
  lane_state_t st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (en) begin
      st_d.held = st_q.cap;   // output stage takes the settled capture first
      st_d.cap  = din;        // then the capture stage takes the new sample
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= st_d;
  end

  assign cap_q  = st_q.cap;
  assign held_q = st_q.held;
endmodule

// File: rtl/isync_lane_select.sv
module isync_lane_select #(
  parameter int LANES = isync_pkg::DEFAULT_LANES,
  localparam int PH_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] lane_q,
  input  logic [PH_W-1:0]  sel,
  output logic             dout
);
  always_comb dout = lane_q[sel];
endmodule

// File: rtl/interleaved_sync.sv
module interleaved_sync #(
  parameter int LANES = isync_pkg::DEFAULT_LANES,
  localparam int PH_W = $clog2(LANES)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [PH_W-1:0]  phase_q;
  logic [PH_W-1:0]  sel;
  logic [LANES-1:0] lane_en;
  logic [LANES-1:0] cap_vec;
  logic [LANES-1:0] out_vec;

  isync_phase_gen #(.LANES(LANES)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .phase   (phase_q),
    .lane_en (lane_en),
    .sel     (sel)
  );

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    isync_lane u_lane (
      .clk    (clk),
      .rst_n  (rst_n),
      .en     (lane_en[i]),
      .din    (async_in),
      .cap_q  (cap_vec[i]),
      .held_q (out_vec[i])
    );
  end

  isync_lane_select #(.LANES(LANES)) u_sel (
    .lane_q (out_vec),
    .sel    (sel),
    .dout   (sync_out)
  );
endmodule

// File: rtl/interleaved_sync_chk.sv
module interleaved_sync_chk #(
  parameter int LANES = isync_pkg::DEFAULT_LANES,
  localparam int PH_W = $clog2(LANES)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             async_in,
  input logic             sync_out,
  input logic [PH_W-1:0]  phase,
  input logic [LANES-1:0] lane_en,
  input logic [LANES-1:0] lane_cap,
  input logic [LANES-1:0] lane_out
);
  // Edges since reset release, saturating.
  logic [2:0] warm_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              warm_q <= '0;
    else if (warm_q != 3'd7) warm_q <= warm_q + 3'd1;
  end

  assert_zero_after_reset_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q <= 3'd4) |-> !sync_out);

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (phase == (($past(phase) == PH_W'(LANES - 1)) ? '0 : PH_W'($past(phase) + 1'b1))));

  assert_single_enable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(lane_en) == 1) && lane_en[phase]);

  for (genvar i = 0; i < LANES; i++) begin : g_lane_chk
    assert_cap_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      lane_en[i] |=> (lane_cap[i] == $past(async_in)));
    assert_cap_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en[i] |=> $stable(lane_cap[i]));
    assert_out_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lane_en[i] |=> (lane_out[i] == $past(lane_cap[i])));
    assert_out_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !lane_en[i] |=> $stable(lane_out[i]));
  end

  assert_select_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q != 3'd0) |-> (sync_out == lane_out[PH_W'($past(phase))]));

  assert_delay_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (warm_q >= 3'd5) |-> (sync_out == $past(async_in, 5)));
endmodule

bind interleaved_sync interleaved_sync_chk #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .async_in (async_in),
  .sync_out (sync_out),
  .phase    (phase_q),
  .lane_en  (lane_en),
  .lane_cap (cap_vec),
  .lane_out (out_vec)
);

// File: tb/interleaved_sync_tb.sv
module interleaved_sync_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 64;
  // Stimulus bits, walked from bit 0 upward: isolated pulses, runs, alternation.
  localparam logic [NVEC-1:0] STIM = 64'hA5F0_0C31_8001_7E4A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic async_in = 1'b0;
  logic sync_out;

  int n_checks = 0;
  int n_fail = 0;
  logic [4:0] hist = '0;   // hist[0] = sample at latest edge

  interleaved_sync u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (async_in),
    .sync_out (sync_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: sync_out=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive one bit for the next edge, then check the output at the following low phase.
  task automatic step(input logic v, input string tag);
    async_in = v;
    @(posedge clk);
    hist = {hist[3:0], v};
    @(negedge clk);
    check(sync_out, hist[4], tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    async_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(sync_out, 1'b0, "R1 in reset");
    hist = '0;
    rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    int ones;
    do_reset();
    // R1: input held high from release, output must stay 0 for four edges.
    for (int k = 0; k < 4; k++) step(1'b1, "R1 warm-up zero");
    step(1'b1, "R1 first sample emerges");

    // R7 / R4 / R5 / R6: table walk against a four-edge delay model.
    for (int k = 0; k < NVEC; k++) step(STIM[k], "R7 R4 R5 R6 table");

    // R7: alternating pattern exercises every lane toggling each visit.
    for (int k = 0; k < 16; k++) step(k[0], "R7 alternating");

    // R8 / R3 / R2: single-cycle pulse captured on each phase in turn.
    for (int p = 0; p < 4; p++) begin
      do_reset();
      ones = 0;
      for (int k = 0; k < p; k++) begin
        step(1'b0, "R2 phase align");
        ones += int'(sync_out);
      end
      step(1'b1, "R8 pulse in");
      ones += int'(sync_out);
      for (int k = 0; k < 8; k++) begin
        step(1'b0, "R8 R3 pulse out");
        ones += int'(sync_out);
      end
      check(ones == 1, 1'b1, "R8 exactly one output pulse");
    end

    // R1: reset taken mid-run with lanes full of ones.
    for (int k = 0; k < 6; k++) step(1'b1, "R7 fill");
    do_reset();
    for (int k = 0; k < 4; k++) step(1'b0, "R1 no stale data");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule